// File: doc/BRIEF.md
# DRAM Command Intake and Write-Data Pairing Front End

This block sits between user logic and the scheduler of a DRAM controller. User logic offers a command code and an address with an enable. The block takes the command in any cycle where that enable and its own command-ready output are both high. Valid commands go into a command queue. Write data arrives on a second channel that has its own enable and a last-beat flag. A burst-length-8 write carries two user beats, and the second beat is marked with the last flag. The block joins the two beats into one pair and stores the pair in a pair queue.

The write data may arrive before its write command, in the same cycle as the command, or up to two cycles after the command is taken. The block therefore does not expect data and command to line up. A dispatcher looks at the head of the command queue. It passes a read on at once. It holds a write until a complete data pair is queued. Requests leave in the order they were accepted, over a valid/ready port to the scheduler.

The dispatcher has three states. FETCH means the output is empty and the dispatcher is looking at the queue head. WAIT_DATA means the head is a write and no pair is queued yet. HOLD means a request is being presented on the output. The transitions are:
- FETCH→HOLD when the head can go (a read, or a write with a pair queued).
- FETCH→WAIT_DATA when the head is a write and no pair is queued.
- WAIT_DATA→HOLD when a pair arrives.
- HOLD→FETCH when the scheduler asserts ready.

Top module: `mc_cmd_front`

## Requirements
- R1: After reset, usr_rdy and wd_rdy are 1, and out_valid and cmd_err are 0.
- R2: A command is taken only at a clock edge where usr_en and usr_rdy are both 1. A command held with usr_en high through cycles where usr_rdy is low is taken exactly once.
- R3: usr_rdy is 0 exactly while the command queue holds CMD_DEPTH entries. With the output stalled, CMD_DEPTH+1 commands can be taken before usr_rdy drops.
- R4: Command code 3'b000 is a write and 3'b001 is a read. Any other code seen at a handshake is not queued. For such a code, cmd_err is 1 for the one cycle after that edge.
- R5: A beat with wd_en=1 and wd_last=0 is the first beat of a pair. A beat with wd_en=1 and wd_last=1 completes the pair. The first beat appears on out_data0 and the second on out_data1.
- R6: Write data pairs with its write command correctly in three cases: data fully before the command, the first beat in the same cycle as the command, and the first beat two cycles after the command is taken.
- R7: A write is presented (out_valid=1) only once both of its beats have been taken. Until then out_valid stays 0.
- R8: Requests leave in acceptance order. A read queued behind a write that is waiting for data also waits. No request is lost or duplicated.
- R9: wd_rdy is 0 exactly while the pair queue holds WD_DEPTH pairs.
- R10: While out_valid=1 and out_ready=0, out_valid, out_is_wr and out_addr stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| usr_en | input | 1 | Command offered |
| usr_cmd | input | 3 | Command code (000 write, 001 read) |
| usr_addr | input | AW | Command address |
| usr_rdy | output | 1 | Command queue has room |
| wd_en | input | 1 | Write-data beat offered |
| wd_last | input | 1 | Beat is the second of its pair |
| wd_data | input | DW | Write-data beat |
| wd_rdy | output | 1 | Pair queue has room |
| cmd_err | output | 1 | Pulse: an unknown code was rejected |
| out_valid | output | 1 | Request presented to the scheduler |
| out_ready | input | 1 | Scheduler takes the request |
| out_is_wr | output | 1 | Presented request is a write |
| out_addr | output | AW | Presented address |
| out_data0 | output | DW | First write beat |
| out_data1 | output | DW | Second write beat |

## Verification
The bench builds the block with CMD_DEPTH=4, WD_DEPTH=2, AW=8 and DW=16. With these small queue depths, both full conditions can be reached in a few cycles. A stalled output fills the command queue after five commands, so a held command sits against a low usr_rdy. Two unclaimed data pairs fill the pair queue and drop wd_rdy. The three orderings of data and command, and a read stuck behind a data-less write, are each driven as their own scenario.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
    localparam logic [2:0] CMD_WR = 3'b000;
    localparam logic [2:0] CMD_RD = 3'b001;

    typedef enum logic [1:0] {
        DS_FETCH     = 2'd0,
        DS_WAIT_DATA = 2'd1,
        DS_HOLD      = 2'd2
    } ds_state_t;
endpackage

// File: rtl/mcf_fifo.sv
module mcf_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    assign dout  = mem[rp];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
endmodule

// File: rtl/mcf_beat_join.sv
module mcf_beat_join #(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wd_en,
    input  logic            wd_last,
    input  logic [DW-1:0]   wd_data,
    input  logic            take_ok,
    output logic            pair_push,
    output logic [2*DW-1:0] pair_data
);
    logic [DW-1:0] first_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) first_q <= '0;
        else if (wd_en && take_ok && !wd_last) first_q <= wd_data;
    end

    assign pair_push = wd_en && take_ok && wd_last;
    assign pair_data = {first_q, wd_data};
endmodule

// File: rtl/mcf_dispatch.sv
module mcf_dispatch
    import mcf_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            head_valid,
    input  logic            head_is_wr,
    input  logic [AW-1:0]   head_addr,
    input  logic            pair_avail,
    input  logic [2*DW-1:0] pair_data,
    input  logic            out_ready,
    output logic            cmd_pop,
    output logic            pair_pop,
    output logic            out_valid,
    output logic            out_is_wr,
    output logic [AW-1:0]   out_addr,
    output logic [DW-1:0]   out_data0,
    output logic [DW-1:0]   out_data1
);
    ds_state_t st, st_nxt;
    logic      load;
    logic      can_take;

    assign can_take = head_valid && (!head_is_wr || pair_avail);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= DS_FETCH;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt   = st;
        load     = 1'b0;
        cmd_pop  = 1'b0;
        pair_pop = 1'b0;
        unique case (st)
            DS_FETCH: begin
                if (can_take) begin
                    load     = 1'b1;
                    cmd_pop  = 1'b1;
                    pair_pop = head_is_wr;
                    st_nxt   = DS_HOLD;
                end else if (head_valid) begin
                    st_nxt = DS_WAIT_DATA;
                end
            end
            DS_WAIT_DATA: begin
                if (pair_avail) begin
                    load     = 1'b1;
                    cmd_pop  = 1'b1;
                    pair_pop = 1'b1;
                    st_nxt   = DS_HOLD;
                end
            end
            DS_HOLD: begin
                if (out_ready) st_nxt = DS_FETCH;
            end
            default: st_nxt = DS_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_is_wr <= 1'b0;
            out_addr  <= '0;
            out_data0 <= '0;
            out_data1 <= '0;
        end else if (load) begin
            out_is_wr <= head_is_wr;
            out_addr  <= head_addr;
            out_data0 <= pair_data[2*DW-1:DW];
            out_data1 <= pair_data[DW-1:0];
        end
    end

    assign out_valid = (st == DS_HOLD);
endmodule

// File: rtl/mc_cmd_front.sv
module mc_cmd_front
    import mcf_pkg::*;
#(
    parameter int AW        = 28,
    parameter int DW        = 64,
    parameter int CMD_DEPTH = 8,
    parameter int WD_DEPTH  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          usr_en,
    input  logic [2:0]    usr_cmd,
    input  logic [AW-1:0] usr_addr,
    output logic          usr_rdy,
    input  logic          wd_en,
    input  logic          wd_last,
    input  logic [DW-1:0] wd_data,
    output logic          wd_rdy,
    output logic          cmd_err,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          out_is_wr,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data0,
    output logic [DW-1:0] out_data1
);
    localparam int CCW = $clog2(CMD_DEPTH + 1);
    localparam int PCW = $clog2(WD_DEPTH + 1);

    logic            code_ok, cmd_push, cmd_pop, cmd_full, cmd_empty;
    logic [AW:0]     cmd_din, cmd_dout;
    logic [CCW-1:0]  cmd_cnt;
    logic            pair_push, pair_pop, pair_full, pair_empty;
    logic [2*DW-1:0] pair_din, pair_dout;
    logic [PCW-1:0]  pair_cnt;

    assign code_ok  = (usr_cmd == CMD_WR) || (usr_cmd == CMD_RD);
    assign cmd_push = usr_en && usr_rdy && code_ok;
    assign cmd_din  = {usr_cmd == CMD_WR, usr_addr};
    assign usr_rdy  = !cmd_full;
    assign wd_rdy   = !pair_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_err <= 1'b0;
        else        cmd_err <= usr_en && usr_rdy && !code_ok;
    end

    mcf_fifo #(.W(AW + 1), .DEPTH(CMD_DEPTH)) u_cmdq (
        .clk(clk), .rst_n(rst_n), .push(cmd_push), .din(cmd_din),
        .pop(cmd_pop), .dout(cmd_dout), .full(cmd_full),
        .empty(cmd_empty), .count(cmd_cnt)
    );

    mcf_beat_join #(.DW(DW)) u_join (
        .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .wd_last(wd_last),
        .wd_data(wd_data), .take_ok(wd_rdy),
        .pair_push(pair_push), .pair_data(pair_din)
    );

    mcf_fifo #(.W(2 * DW), .DEPTH(WD_DEPTH)) u_pairq (
        .clk(clk), .rst_n(rst_n), .push(pair_push), .din(pair_din),
        .pop(pair_pop), .dout(pair_dout), .full(pair_full),
        .empty(pair_empty), .count(pair_cnt)
    );

    mcf_dispatch #(.AW(AW), .DW(DW)) u_disp (
        .clk(clk), .rst_n(rst_n),
        .head_valid(!cmd_empty), .head_is_wr(cmd_dout[AW]),
        .head_addr(cmd_dout[AW-1:0]),
        .pair_avail(!pair_empty), .pair_data(pair_dout),
        .out_ready(out_ready), .cmd_pop(cmd_pop), .pair_pop(pair_pop),
        .out_valid(out_valid), .out_is_wr(out_is_wr), .out_addr(out_addr),
        .out_data0(out_data0), .out_data1(out_data1)
    );
endmodule

// File: rtl/mcf_chk.sv
module mcf_chk #(
    parameter int AW        = 8,
    parameter int CMD_DEPTH = 4,
    parameter int WD_DEPTH  = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           usr_en,
    input logic                           usr_rdy,
    input logic [2:0]                     usr_cmd,
    input logic                           cmd_err,
    input logic                           out_valid,
    input logic                           out_ready,
    input logic                           out_is_wr,
    input logic [AW-1:0]                  out_addr,
    input logic [$clog2(CMD_DEPTH+1)-1:0] cmd_cnt,
    input logic [$clog2(WD_DEPTH+1)-1:0]  pair_cnt
);
    localparam int CCW = $clog2(CMD_DEPTH + 1);
    localparam int PCW = $clog2(WD_DEPTH + 1);

    // R4: a bad code at a handshake yields an error pulse next cycle
    p_err_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        usr_en && usr_rdy && (usr_cmd > 3'd1) |=> cmd_err);

    // R4: an error pulse always has a bad handshake as its cause
    p_err_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(usr_en && usr_rdy && (usr_cmd > 3'd1)));

    // R10: presented request is frozen while the scheduler stalls
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_is_wr));

    // R7: a write appears only if a pair was queued at the loading edge
    p_wr_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) && out_is_wr |-> $past(pair_cnt) != '0);

    // R3: the command queue never exceeds its depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_cnt <= CCW'(CMD_DEPTH));

    // R9: the pair queue never exceeds its depth
    p_pair_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pair_cnt <= PCW'(WD_DEPTH));
endmodule

bind mc_cmd_front mcf_chk #(.AW(AW), .CMD_DEPTH(CMD_DEPTH), .WD_DEPTH(WD_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .usr_en(usr_en), .usr_rdy(usr_rdy),
    .usr_cmd(usr_cmd), .cmd_err(cmd_err), .out_valid(out_valid),
    .out_ready(out_ready), .out_is_wr(out_is_wr), .out_addr(out_addr),
    .cmd_cnt(cmd_cnt), .pair_cnt(pair_cnt)
);

// File: tb/mc_cmd_front_tb_top.sv
module mc_cmd_front_tb_top;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int CD = 4;
    localparam int WD = 2;

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] d0;
        logic [DW-1:0] d1;
    } req_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic usr_en = 1'b0;
    logic [2:0] usr_cmd = 3'b000;
    logic [AW-1:0] usr_addr = '0;
    logic usr_rdy;
    logic wd_en = 1'b0;
    logic wd_last = 1'b0;
    logic [DW-1:0] wd_data = '0;
    logic wd_rdy, cmd_err, out_valid, out_is_wr;
    logic out_ready = 1'b1;
    logic [AW-1:0] out_addr;
    logic [DW-1:0] out_data0, out_data1;

    int vectors = 0;
    int fails = 0;
    bit finished = 1'b0;
    req_t exp_q[$];

    always #4 clk = ~clk;

    mc_cmd_front #(.AW(AW), .DW(DW), .CMD_DEPTH(CD), .WD_DEPTH(WD)) dut_i (
        .clk(clk), .rst_n(rst_n), .usr_en(usr_en), .usr_cmd(usr_cmd),
        .usr_addr(usr_addr), .usr_rdy(usr_rdy), .wd_en(wd_en),
        .wd_last(wd_last), .wd_data(wd_data), .wd_rdy(wd_rdy),
        .cmd_err(cmd_err), .out_valid(out_valid), .out_ready(out_ready),
        .out_is_wr(out_is_wr), .out_addr(out_addr),
        .out_data0(out_data0), .out_data1(out_data1)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Output monitor: R8 order, R5/R6 pairing, no extra requests
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            vectors++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R8 unexpected request actual=%0h expected=none", out_addr);
            end else begin
                req_t e;
                e = exp_q.pop_front();
                if (out_is_wr !== e.wr || out_addr !== e.addr ||
                    (e.wr && (out_data0 !== e.d0 || out_data1 !== e.d1))) begin
                    fails++;
                    $display("FAIL R8 R5 R6 actual=%0h/%0h/%0h/%0h expected=%0h/%0h/%0h/%0h",
                             out_is_wr, out_addr, out_data0, out_data1,
                             e.wr, e.addr, e.d0, e.d1);
                end
            end
        end
    end

    task automatic send_cmd(input logic [2:0] c, input logic [AW-1:0] a);
        logic took;
        usr_cmd = c; usr_addr = a; usr_en = 1'b1;
        do begin
            took = usr_rdy;
            @(posedge clk); #2;
        end while (!took);
        usr_en = 1'b0;
    endtask

    task automatic send_beat(input logic [DW-1:0] d, input logic last);
        logic took;
        wd_data = d; wd_last = last; wd_en = 1'b1;
        do begin
            took = wd_rdy;
            @(posedge clk); #2;
        end while (!took);
        wd_en = 1'b0; wd_last = 1'b0;
    endtask

    task automatic send_pair(input logic [DW-1:0] d0, input logic [DW-1:0] d1);
        send_beat(d0, 1'b0);
        send_beat(d1, 1'b1);
    endtask

    task automatic expect_req(input logic wr, input logic [AW-1:0] a,
                              input logic [DW-1:0] d0, input logic [DW-1:0] d1);
        req_t e;
        e.wr = wr; e.addr = a; e.d0 = d0; e.d1 = d1;
        exp_q.push_back(e);
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 60 && exp_q.size() != 0; i++) begin
            @(posedge clk); #2;
        end
        chk({tag, " R8 lost requests"}, 64'(exp_q.size()), 64'd0);
    endtask

    task automatic t_reset();
        chk("R1 usr_rdy", 64'(usr_rdy), 64'd1);
        chk("R1 wd_rdy", 64'(wd_rdy), 64'd1);
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 cmd_err", 64'(cmd_err), 64'd0);
    endtask

    task automatic t_read();
        expect_req(1'b0, 8'h11, '0, '0);
        send_cmd(3'b001, 8'h11);
        drain("R8 read");
    endtask

    task automatic t_same_cycle();
        expect_req(1'b1, 8'h22, 16'hA001, 16'hA002);
        fork
            send_cmd(3'b000, 8'h22);
            send_pair(16'hA001, 16'hA002);
        join
        drain("R6 same cycle");
    endtask

    task automatic t_data_first();
        expect_req(1'b1, 8'h33, 16'hB001, 16'hB002);
        send_pair(16'hB001, 16'hB002);
        repeat (3) begin @(posedge clk); #2; end
        chk("R7 no cmd yet out_valid", 64'(out_valid), 64'd0);
        send_cmd(3'b000, 8'h33);
        drain("R6 data first");
    endtask

    task automatic t_trailing();
        expect_req(1'b1, 8'h44, 16'hC001, 16'hC002);
        fork
            send_cmd(3'b000, 8'h44);
            begin
                repeat (2) @(posedge clk);
                #2;
                send_pair(16'hC001, 16'hC002);
            end
        join
        drain("R6 trailing two cycles");
    endtask

    task automatic t_read_behind_write();
        expect_req(1'b1, 8'h55, 16'hD001, 16'hD002);
        expect_req(1'b0, 8'h56, '0, '0);
        send_cmd(3'b000, 8'h55);
        send_cmd(3'b001, 8'h56);
        repeat (5) begin @(posedge clk); #2; end
        chk("R7 R8 waiting write blocks", 64'(out_valid), 64'd0);
        send_pair(16'hD001, 16'hD002);
        drain("R8 read behind write");
    endtask

    task automatic t_bad_code();
        send_cmd(3'b101, 8'h66);
        chk("R4 cmd_err pulse", 64'(cmd_err), 64'd1);
        @(posedge clk); #2;
        chk("R4 cmd_err clears", 64'(cmd_err), 64'd0);
        repeat (4) begin @(posedge clk); #2; end
        chk("R4 nothing queued", 64'(out_valid), 64'd0);
    endtask

    task automatic t_stall();
        out_ready = 1'b0;
        for (int i = 0; i < CD + 2; i++) expect_req(1'b0, 8'(8'h70 + i), '0, '0);
        for (int i = 0; i < CD + 1; i++) send_cmd(3'b001, 8'(8'h70 + i));
        chk("R3 usr_rdy low when full", 64'(usr_rdy), 64'd0);
        chk("R10 head presented", 64'({out_valid, out_addr}), 64'({1'b1, 8'h70}));
        fork
            send_cmd(3'b001, 8'(8'h70 + CD + 1));
            begin
                repeat (4) begin @(posedge clk); #2; end
                chk("R10 held under stall", 64'({out_valid, out_addr}), 64'({1'b1, 8'h70}));
                chk("R2 still not taken", 64'(usr_rdy), 64'd0);
                out_ready = 1'b1;
            end
        join
        drain("R2 R3 stall");
        chk("R3 usr_rdy back", 64'(usr_rdy), 64'd1);
    endtask

    task automatic t_wd_full();
        for (int i = 0; i < WD; i++) send_pair(16'(16'hE000 + 2 * i), 16'(16'hE001 + 2 * i));
        chk("R9 wd_rdy low when full", 64'(wd_rdy), 64'd0);
        for (int i = 0; i < WD; i++) begin
            expect_req(1'b1, 8'(8'h90 + i), 16'(16'hE000 + 2 * i), 16'(16'hE001 + 2 * i));
            send_cmd(3'b000, 8'(8'h90 + i));
        end
        drain("R9 drain pairs");
        chk("R9 wd_rdy back", 64'(wd_rdy), 64'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        rst_n = 1'b1;
        @(posedge clk); #2;
        t_read();
        t_same_cycle();
        t_data_first();
        t_trailing();
        t_read_behind_write();
        t_bad_code();
        t_stall();
        t_wd_full();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            vectors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule